// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block connects one voice channel to a shared PCM serial bus. A bit clock times the bus and a frame sync pulse marks the first bit of each frame. The channel owns a programmable time slot. While that slot is on the bus, the block shifts its transmit sample out one bit per bit clock and collects the receive sample one bit per bit clock. The core side sees plain parallel words. It supplies a transmit word, which is taken at frame sync, and it gets back a received word with a one-cycle strobe.

An 8-bit control byte shapes the slot traffic. It selects between an 8-bit companded word in one slot and a 16-bit two's complement word in two adjacent slots. It also sets the bit order, the law for the idle code, a forced-zero transmit, a high-impedance transmit, idle-code substitution on the receive side, and two loopback paths. The block runs on a fast system clock and oversamples the bit clock. Transmit bits change after each bit clock rising edge, and receive bits are taken at each falling edge. Only one bit per bit clock is supported.

Top module: `pcm_slot_port`

## Requirements
- R1: A bit clock rising edge that finds frame sync high is bit 0 of the frame. Bit n lies n rising edges later. The channel window starts at bit 8 × `slot` and the driver is never enabled outside that window.
- R2: With control bits 0 and 1 clear and standby low, `tx_oe` is high for each bit of the window. The window is 8 bits when control bit 6 is 0 and 16 bits when it is 1.
- R3: Control bit 0 (three-state) or a high `standby` holds `tx_oe` low, including during the window.
- R4: With control bit 1 (send zeros) set, every transmitted bit of the window is 0.
- R5: Control bit 2 set sends and receives the most significant bit first. Cleared (the reset value of the byte), both directions go least significant bit first.
- R6: Control bit 6 set selects 16-bit linear words over two adjacent slots. Cleared, it selects 8-bit words, and `rx_word[15:8]` is delivered as 0.
- R7: Control bit 3 set replaces the delivered word with the idle code. The idle code is 0x00FF for μ-law (bit 7 = 0), 0x00D5 for A-law (bit 7 = 1), and 0x0000 in linear mode.
- R8: Control bit 4 (digital loopback) set transmits the last delivered `rx_word`, taken at frame sync, instead of `tx_word`.
- R9: Control bit 5 (analog loopback) set makes the receive side take the bits the transmitter places on `tx_out`, instead of `rx_in`.
- R10: The transmit word is latched at frame sync. A change of `tx_word` later in the frame does not alter that frame's slot data.
- R11: `rx_valid` pulses for exactly one clock after the falling edge of the last window bit. `rx_word` changes only with that pulse.
- R12: After reset, `rx_word` is 0, `rx_valid` is 0 and `tx_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | PCM bit clock |
| fsync | input | 1 | Frame sync, high during bit 0 of the frame |
| slot | input | SLOT_W | Assigned time-slot number |
| ctrl_byte | input | 8 | Options: 0 three-state, 1 send zeros, 2 MSB first, 3 idle code, 4 digital loop, 5 analog loop, 6 linear, 7 A-law |
| standby | input | 1 | Forces the transmit driver off |
| tx_word | input | 16 | Transmit sample from the core |
| tx_out | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Transmit driver enable (low means high impedance) |
| rx_in | input | 1 | Receive serial data |
| rx_word | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
The assertions check several things on every cycle:
- frame sync clears the bit position, and the bit position otherwise advances by one per rising edge;
- the driver is off after a bit tick outside the window;
- forced zeros reach the line;
- the transmit latch holds between frame syncs;
- the receive strobe lasts one cycle, with no word change without it, a clear upper byte in companded mode and the idle code when selected.

Only the bench scenarios can show the serial content. That covers bit order in both directions, placement of a slot at either end of the frame, both loopback routes, and the mid-frame change of the transmit word. The bench compares these whole words against its own model.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  // Number of bits in one sample for the selected word format.
  function automatic logic [4:0] word_len(input logic linear);
    return linear ? 5'd16 : 5'd8;
  endfunction

  // Code delivered instead of a received sample when idle substitution is on.
  function automatic logic [15:0] idle_word(input logic alaw, input logic linear);
    if (linear)    return 16'h0000;
    else if (alaw) return 16'h00D5;
    else           return 16'h00FF;
  endfunction

  // Word bit carried by serial position k of the window.
  function automatic logic [3:0] bit_index(input logic [3:0] k, input logic msb_first,
                                           input logic linear);
    if (!msb_first)  return k;
    else if (linear) return 4'd15 - k;
    else             return 4'd7 - k;
  endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_slot_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_W     = 5,
  parameter int IN_STAGES  = 1,
  localparam int CNT_W     = $clog2(FRAME_BITS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              rx_in,
  input  logic [SLOT_W-1:0] slot,
  input  logic              linear,
  output logic              bit_tick,
  output logic              frame_tick,
  output logic              sample_tick,
  output logic              in_slot,
  output logic [3:0]        slot_pos,
  output logic              last_pos,
  output logic              rx_line
);

  localparam logic [CNT_W-1:0] CNT_IDLE = '1;

  // Input capture pipeline: {bclk, fsync, rx_in}
  logic [2:0] stage_q [IN_STAGES];

  generate
    for (genvar i = 0; i < IN_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= {bclk, fsync, rx_in};
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[i] <= '0;
          else        stage_q[i] <= stage_q[i-1];
      end
    end
  endgenerate

  logic bclk_s, fs_s, bclk_prev;
  assign bclk_s  = stage_q[IN_STAGES-1][2];
  assign fs_s    = stage_q[IN_STAGES-1][1];
  assign rx_line = stage_q[IN_STAGES-1][0];

  logic rise, fall;
  assign rise = bclk_s & ~bclk_prev;
  assign fall = ~bclk_s & bclk_prev;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev  <= 1'b0;
      cnt        <= CNT_IDLE;
      bit_tick   <= 1'b0;
      frame_tick <= 1'b0;
    end else begin
      bclk_prev  <= bclk_s;
      bit_tick   <= rise;
      frame_tick <= rise & fs_s;
      if (rise) begin
        if (fs_s)                  cnt <= '0;
        else if (cnt != CNT_IDLE)  cnt <= cnt + 1'b1;
      end
    end
  end

  // Window arithmetic, one bit wider than the counter.
  logic [CNT_W:0] cnt_x, start_x, end_x, diff_x;
  logic [4:0]     len;

  always_comb begin
    len     = word_len(linear);
    cnt_x   = {1'b0, cnt};
    start_x = '0;
    start_x[SLOT_W+2:0] = {slot, 3'b000};
    end_x   = start_x + (CNT_W+1)'(len);
    diff_x  = cnt_x - start_x;
  end

  assign in_slot     = (cnt_x >= start_x) && (cnt_x < end_x);
  assign slot_pos    = diff_x[3:0];
  assign last_pos    = in_slot && ({1'b0, slot_pos} == len - 5'd1);
  assign sample_tick = fall;

  p_sync_clears_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && fs_s) |=> (cnt == '0));

  p_count_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !fs_s && cnt != CNT_IDLE) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hiz,
  input  logic        send_zero,
  input  logic        msb_first,
  input  logic        dig_loop,
  input  logic        linear,
  input  logic        standby,
  input  logic        bit_tick,
  input  logic        frame_tick,
  input  logic        in_slot,
  input  logic [3:0]  slot_pos,
  input  logic [15:0] tx_word,
  input  logic [15:0] loop_word,
  output logic        tx_out,
  output logic        tx_oe
);

  logic [15:0] hold_q, src, cur;
  logic        nxt_bit, line_q, act_q;

  assign src     = dig_loop ? loop_word : tx_word;
  assign cur     = frame_tick ? src : hold_q;
  assign nxt_bit = send_zero ? 1'b0 : cur[bit_index(slot_pos, msb_first, linear)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      line_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (frame_tick) hold_q <= src;
      if (bit_tick) begin
        line_q <= in_slot ? nxt_bit : 1'b0;
        act_q  <= in_slot;
      end
    end
  end

  assign tx_out = line_q;
  assign tx_oe  = act_q & ~hiz & ~standby;

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && in_slot && send_zero) |=> !tx_out);

  p_quiet_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !in_slot) |=> !tx_oe);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> (hold_q == $past(hold_q)));

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msb_first,
  input  logic        idle,
  input  logic        ana_loop,
  input  logic        linear,
  input  logic        alaw,
  input  logic        sample_tick,
  input  logic        in_slot,
  input  logic [3:0]  slot_pos,
  input  logic        last_pos,
  input  logic        rx_line,
  input  logic        line_bit,
  output logic [15:0] rx_word,
  output logic        rx_valid
);

  logic [15:0] acc_q, acc_n, done_w;
  logic        in_bit;
  logic [3:0]  idx;

  assign in_bit = ana_loop ? line_bit : rx_line;
  assign idx    = bit_index(slot_pos, msb_first, linear);

  always_comb begin
    acc_n      = acc_q;
    acc_n[idx] = in_bit;
    done_w     = acc_n;
    if (!linear) done_w[15:8] = 8'h00;
    if (idle)    done_w = idle_word(alaw, linear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sample_tick && in_slot) begin
        acc_q <= acc_n;
        if (last_pos) begin
          rx_word  <= done_w;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_word_moves_with_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word != $past(rx_word)) |-> rx_valid);

  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !linear) |-> (rx_word[15:8] == 8'h00));

  p_idle_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && idle) |-> (rx_word == idle_word(alaw, linear)));

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_W     = 5,
  parameter int IN_STAGES  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic [SLOT_W-1:0] slot,
  input  logic [7:0]        ctrl_byte,
  input  logic              standby,
  input  logic [15:0]       tx_word,
  output logic              tx_out,
  output logic              tx_oe,
  input  logic              rx_in,
  output logic [15:0]       rx_word,
  output logic              rx_valid
);

  // Control byte fields
  logic c_hiz, c_zero, c_msb, c_idle, c_dloop, c_aloop, c_linear, c_alaw;
  assign c_hiz    = ctrl_byte[0];
  assign c_zero   = ctrl_byte[1];
  assign c_msb    = ctrl_byte[2];
  assign c_idle   = ctrl_byte[3];
  assign c_dloop  = ctrl_byte[4];
  assign c_aloop  = ctrl_byte[5];
  assign c_linear = ctrl_byte[6];
  assign c_alaw   = ctrl_byte[7];

  // Events between the timer and the two data paths
  logic       bit_tick, frame_tick, sample_tick, in_slot, last_pos, rx_line;
  logic [3:0] slot_pos;

  pcm_frame_timer #(
    .FRAME_BITS(FRAME_BITS),
    .SLOT_W    (SLOT_W),
    .IN_STAGES (IN_STAGES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .fsync      (fsync),
    .rx_in      (rx_in),
    .slot       (slot),
    .linear     (c_linear),
    .bit_tick   (bit_tick),
    .frame_tick (frame_tick),
    .sample_tick(sample_tick),
    .in_slot    (in_slot),
    .slot_pos   (slot_pos),
    .last_pos   (last_pos),
    .rx_line    (rx_line)
  );

  pcm_tx_path u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .hiz       (c_hiz),
    .send_zero (c_zero),
    .msb_first (c_msb),
    .dig_loop  (c_dloop),
    .linear    (c_linear),
    .standby   (standby),
    .bit_tick  (bit_tick),
    .frame_tick(frame_tick),
    .in_slot   (in_slot),
    .slot_pos  (slot_pos),
    .tx_word   (tx_word),
    .loop_word (rx_word),
    .tx_out    (tx_out),
    .tx_oe     (tx_oe)
  );

  pcm_rx_path u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .msb_first  (c_msb),
    .idle       (c_idle),
    .ana_loop   (c_aloop),
    .linear     (c_linear),
    .alaw       (c_alaw),
    .sample_tick(sample_tick),
    .in_slot    (in_slot),
    .slot_pos   (slot_pos),
    .last_pos   (last_pos),
    .rx_line    (rx_line),
    .line_bit   (tx_out),
    .rx_word    (rx_word),
    .rx_valid   (rx_valid)
  );

  p_standby_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (standby || c_hiz) |-> !tx_oe);

endmodule

// File: tb/pcm_slot_port_bench.sv
`timescale 1ns/1ps
module pcm_slot_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, standby = 1'b0, rx_in = 1'b0;
  logic [4:0]  slot = '0;
  logic [7:0]  ctrl_byte = '0;
  logic [15:0] tx_word = '0;
  logic        tx_out, tx_oe, rx_valid;
  logic [15:0] rx_word;

  always #2.5 clk = ~clk;

  pcm_slot_port u_pcm_slot_port (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .slot(slot),
    .ctrl_byte(ctrl_byte), .standby(standby), .tx_word(tx_word),
    .tx_out(tx_out), .tx_oe(tx_oe), .rx_in(rx_in),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  int vectors = 0, fails = 0, strobes = 0;
  logic [15:0] strobe_word = '0;
  logic [15:0] last_rx = '0;
  bit finished = 0;

  always @(negedge clk) if (rx_valid) begin
    strobes++;
    strobe_word = rx_word;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_idle(logic [7:0] c);
    if (c[6]) return 16'h0000;
    return c[7] ? 16'h00D5 : 16'h00FF;
  endfunction

  function automatic logic [15:0] mask_len(logic [15:0] w, logic lin);
    return lin ? w : {8'h00, w[7:0]};
  endfunction

  task automatic run_frame(int s, logic [7:0] c, logic [15:0] txw, logic [15:0] rxw, logic sb);
    int L = c[6] ? 16 : 8;
    int st = 8 * s;
    int nbits = st + L + 2;
    logic [15:0] exp_tx, cap_tx, exp_rx;
    int oe_bad_in = 0, oe_bad_out = 0, n0;
    logic exp_oe = !c[0] && !sb;
    string ttag;
    @(negedge clk);
    slot = s[4:0]; ctrl_byte = c; standby = sb; tx_word = txw;
    exp_tx = c[4] ? last_rx : txw;
    if (c[1]) exp_tx = '0;
    exp_tx = mask_len(exp_tx, c[6]);
    cap_tx = '0;
    n0 = strobes;
    for (int b = 0; b < nbits; b++) begin
      bit insl = (b >= st) && (b < st + L);
      int pos = 0;
      if (insl) pos = c[2] ? (L - 1 - (b - st)) : (b - st);
      bclk = 1'b1; fsync = (b == 0);
      rx_in = insl ? rxw[pos] : 1'b1;
      if (b == 1) tx_word = ~txw;
      repeat (4) @(negedge clk);
      if (insl) begin
        cap_tx[pos] = tx_out;
        if (tx_oe !== exp_oe) oe_bad_in++;
      end else if (tx_oe !== 1'b0) oe_bad_out++;
      bclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    exp_rx = c[5] ? exp_tx : mask_len(rxw, c[6]);
    if (c[3]) exp_rx = model_idle(c);
    ttag = c[4] ? "R8" : c[1] ? "R4" : c[6] ? "R6" : c[2] ? "R5" : "R10";
    chk(ttag, "tx word", {16'h0, cap_tx}, {16'h0, exp_tx});
    chk("R1", "driver outside window", oe_bad_out, 0);
    chk(exp_oe ? "R2" : "R3", "driver in window", oe_bad_in, 0);
    chk("R11", "strobe count", strobes - n0, 1);
    chk(c[3] ? "R7" : c[5] ? "R9" : "R5", "rx word", {16'h0, strobe_word}, {16'h0, exp_rx});
    last_rx = exp_rx;
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!finished) begin
      fails++; vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7);
    repeat (3) @(negedge clk);
    chk("R12", "reset rx_word", {16'h0, rx_word}, 32'h0);
    chk("R12", "reset rx_valid", {31'h0, rx_valid}, 32'h0);
    chk("R12", "reset tx_oe", {31'h0, tx_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(0,  8'h00, 16'h005A, 16'h003C, 1'b0); // R5 default LSB first
    run_frame(30, 8'h44, 16'hA5C3, 16'h1234, 1'b0); // R6 linear, last slot pair
    run_frame(3,  8'h01, 16'h0077, 16'h0011, 1'b0); // R3 three-state
    run_frame(2,  8'h04, 16'h00E1, 16'h0081, 1'b1); // R3 standby
    run_frame(1,  8'h02, 16'h00FF, 16'h0042, 1'b0); // R4 zeros
    run_frame(4,  8'h88, 16'h0012, 16'h0034, 1'b0); // R7 A-law idle
    run_frame(5,  8'h08, 16'h0012, 16'h0034, 1'b0); // R7 mu-law idle
    run_frame(6,  8'h48, 16'h1111, 16'h2222, 1'b0); // R7 linear idle
    run_frame(0,  8'h04, 16'h0000, 16'h00C9, 1'b0); // prime last_rx
    run_frame(7,  8'h10, 16'h0033, 16'h0055, 1'b0); // R8 digital loop
    run_frame(8,  8'h24, 16'h00B4, 16'h0000, 1'b0); // R9 analog loop
    for (int i = 0; i < 30; i++) begin
      logic [7:0] c = 8'($urandom);
      run_frame($urandom_range(0, 30), c, 16'($urandom), 16'($urandom),
                ($urandom_range(0, 7) == 0));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule